// File: doc/BRIEF.md
# Tick-Paced Serial Bit Shifter

This block sends the contents of a transmit buffer, one bit at a time, on a single output line. It has no baud divider of its own. Each bit is paced by a tick that comes from elsewhere, usually the overflow pulse of a neighbouring timer. A write to the buffer stores the byte and arms a transmission of `DATA_W` bits. Each accepted tick drives the next bit, starting with the most significant one. No start or stop bits are added.

A serial-mode enable input gates the whole shifter. When the last bit has been driven, a completion flag is set. If interrupts are enabled at that moment, an interrupt request is raised as well. Software clears both with a single clear pulse. On every tick it accepts, the block returns a same-cycle pulse, so the timer that produced the tick can drop its overflow flag.

Top module: `sertx_top`

## Requirements
- R1: After a synchronous active-low reset, `ser_out` is 1, `tx_done` is 0, `irq_req` is 0, `tick_taken` is 0 and no bits are pending.
- R2: A cycle with `buf_wr` high stores `buf_data` and sets the pending-bit count to `DATA_W`. Exactly `DATA_W` accepted ticks then follow before completion.
- R3: An accepted tick decrements the pending count, and `ser_out` takes the stored bit at index (new count) on the next clock edge. Bits therefore leave most-significant first.
- R4: While `mode_en` is 0, ticks are not accepted. The count, `ser_out` and the flags are left unchanged.
- R5: The tick that brings the pending count to zero sets `tx_done` on the next clock edge.
- R6: On completion, `irq_req` is set only if `irq_en` is 1 in that cycle. Otherwise `irq_req` keeps its value.
- R7: `tick_taken` is high in exactly those cycles in which a tick is accepted (`baud_tick`, `mode_en`, a nonzero pending count, no buffer write). It is a combinational pulse.
- R8: With a pending count of zero, ticks are ignored. There is no `tick_taken` and no change at the outputs.
- R9: A buffer write during a transmission restarts it with the new byte and a full count. In a cycle that has both a write and a tick, the write wins and the tick is not taken.
- R10: `done_clr` clears `tx_done` and `irq_req` on the next edge. If completion happens in the same cycle, the set takes priority for the flag being set.
- R11: Between accepted ticks, `ser_out` holds its last value, including after completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| buf_wr | input | 1 | Transmit buffer write strobe |
| buf_data | input | DATA_W | Byte to transmit |
| baud_tick | input | 1 | Bit-rate tick from a timer overflow |
| mode_en | input | 1 | Serial shift mode enable |
| irq_en | input | 1 | Interrupt enable for completion |
| done_clr | input | 1 | Software clear of completion flag and request |
| ser_out | output | 1 | Serial data line |
| tx_done | output | 1 | Transmission complete flag |
| irq_req | output | 1 | Interrupt request |
| tick_taken | output | 1 | Tick consumed; tells the timer to clear its overflow flag |

## Verification
The bench builds the block with the default `DATA_W` of 8. This makes the 4-bit counter run through every value from 8 down to 0, and it shows that the buffer index is correctly truncated from the counter width. A full frame takes only 8 accepted ticks. Long random runs can therefore complete hundreds of frames, with writes landing at every count value, including on a completion cycle and in the same cycle as a tick.

// File: rtl/sertx_pkg.sv
// Shared types and helpers for the tick-paced serial shifter.
// Assumes DATA_W >= 2 so that a bit index has at least one bit.
package sertx_pkg;

    // Width of a counter that must hold values 0..n inclusive.
    function automatic int cnt_width(input int n);
        return $clog2(n + 1);
    endfunction

    // Per-cycle control decisions passed from the counter to the other parts.
    typedef struct packed {
        logic load;   // buffer write this cycle
        logic take;   // a tick is consumed this cycle
        logic last;   // the consumed tick sends the final bit
    } sertx_ctl_t;

endpackage

// File: rtl/sertx_count.sv
// Pending-bit counter. Decides whether a tick is consumed and tracks how
// many bits remain. Assumes the write strobe has priority over a tick.
module sertx_count
    import sertx_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int CNT_W = cnt_width(DATA_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             buf_wr,
    input  logic             baud_tick,
    input  logic             mode_en,
    output sertx_ctl_t       ctl,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] cnt_dec
);

    logic busy;

    // Decode the control decisions for this cycle.
    always_comb begin
        busy     = (cnt_q != '0);
        cnt_dec  = cnt_q - CNT_W'(1);
        ctl.load = buf_wr;
        ctl.take = baud_tick && mode_en && busy && !buf_wr;
        ctl.last = ctl.take && (cnt_q == CNT_W'(1));
    end

    // Reload on a write, count down on each consumed tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (ctl.load) begin
            cnt_q <= CNT_W'(DATA_W);
        end else if (ctl.take) begin
            cnt_q <= cnt_dec;
        end
    end

endmodule

// File: rtl/sertx_shift.sv
// Buffer and output stage. Stores the written byte and drives the bit
// selected by the decremented count when a tick is consumed.
// Assumes cnt_dec < DATA_W whenever ctl.take is high.
module sertx_shift
    import sertx_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int CNT_W = cnt_width(DATA_W),
    localparam int IDX_W = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  sertx_ctl_t        ctl,
    input  logic [DATA_W-1:0] buf_data,
    input  logic [CNT_W-1:0]  cnt_dec,
    output logic              ser_out
);

    logic [DATA_W-1:0] buf_q;
    logic [IDX_W-1:0]  sel;

    // Truncate the next count to a buffer index.
    always_comb begin
        sel = cnt_dec[IDX_W-1:0];
    end

    // Hold the byte being sent.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_q <= '0;
        end else if (ctl.load) begin
            buf_q <= buf_data;
        end
    end

    // Drive the selected bit; idle high after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ser_out <= 1'b1;
        end else if (ctl.take) begin
            ser_out <= buf_q[sel];
        end
    end

endmodule

// File: rtl/sertx_flags.sv
// Completion flag and interrupt request. Completion sets the flag always and
// the request only when enabled; a clear loses against a same-cycle set.
module sertx_flags
    import sertx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  sertx_ctl_t ctl,
    input  logic       irq_en,
    input  logic       done_clr,
    output logic       tx_done,
    output logic       irq_req
);

    logic set_irq;

    // Qualify the request with the enable.
    always_comb begin
        set_irq = ctl.last && irq_en;
    end

    // Completion flag: set on last bit, cleared by software.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_done <= 1'b0;
        end else if (ctl.last) begin
            tx_done <= 1'b1;
        end else if (done_clr) begin
            tx_done <= 1'b0;
        end
    end

    // Interrupt request: set on enabled completion, cleared by software.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_req <= 1'b0;
        end else if (set_irq) begin
            irq_req <= 1'b1;
        end else if (done_clr) begin
            irq_req <= 1'b0;
        end
    end

endmodule

// File: rtl/sertx_top.sv
// Tick-paced serial shifter, top level. Sends DATA_W bits MSB first, one per
// accepted external tick, with no framing. Assumes DATA_W >= 2.
module sertx_top
    import sertx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              buf_wr,
    input  logic [DATA_W-1:0] buf_data,
    input  logic              baud_tick,
    input  logic              mode_en,
    input  logic              irq_en,
    input  logic              done_clr,
    output logic              ser_out,
    output logic              tx_done,
    output logic              irq_req,
    output logic              tick_taken
);

    localparam int CNT_W = cnt_width(DATA_W);

    sertx_ctl_t       ctl;
    logic [CNT_W-1:0] bit_cnt;
    logic [CNT_W-1:0] cnt_dec;

    sertx_count #(.DATA_W(DATA_W)) u_count (
        .clk       (clk),
        .rst_n     (rst_n),
        .buf_wr    (buf_wr),
        .baud_tick (baud_tick),
        .mode_en   (mode_en),
        .ctl       (ctl),
        .cnt_q     (bit_cnt),
        .cnt_dec   (cnt_dec)
    );

    sertx_shift #(.DATA_W(DATA_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctl      (ctl),
        .buf_data (buf_data),
        .cnt_dec  (cnt_dec),
        .ser_out  (ser_out)
    );

    sertx_flags u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctl      (ctl),
        .irq_en   (irq_en),
        .done_clr (done_clr),
        .tx_done  (tx_done),
        .irq_req  (irq_req)
    );

    // Report the consumed tick to the timer.
    always_comb begin
        tick_taken = ctl.take;
    end

endmodule

// File: rtl/sertx_check.sv
// Temporal checks on the serial shifter, attached to every instance by bind.
module sertx_check
    import sertx_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int CNT_W = cnt_width(DATA_W)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             buf_wr,
    input logic             baud_tick,
    input logic             mode_en,
    input logic             irq_en,
    input logic             done_clr,
    input logic             ser_out,
    input logic             tx_done,
    input logic             irq_req,
    input logic             tick_taken,
    input logic [CNT_W-1:0] bit_cnt
);

    assert_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
        buf_wr |=> (bit_cnt == CNT_W'(DATA_W)));

    assert_mode_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
        tick_taken |-> (mode_en && baud_tick && !buf_wr));

    assert_idle_ignore_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_cnt == '0) |-> !tick_taken);

    assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_taken |=> $stable(ser_out));

    assert_done_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_done) |-> $past(tick_taken));

    assert_irq_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_req) |-> $past(irq_en && tick_taken));

    assert_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (done_clr && !(tick_taken && bit_cnt == CNT_W'(1))) |=> !tx_done);

endmodule

bind sertx_top sertx_check #(.DATA_W(DATA_W)) u_sertx_check (
    .clk        (clk),
    .rst_n      (rst_n),
    .buf_wr     (buf_wr),
    .baud_tick  (baud_tick),
    .mode_en    (mode_en),
    .irq_en     (irq_en),
    .done_clr   (done_clr),
    .ser_out    (ser_out),
    .tx_done    (tx_done),
    .irq_req    (irq_req),
    .tick_taken (tick_taken),
    .bit_cnt    (bit_cnt)
);

// File: tb/test_sertx_top.sv
`timescale 1ns/1ps
module test_sertx_top;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         buf_wr = 1'b0;
    logic [W-1:0] buf_data = '0;
    logic         baud_tick = 1'b0;
    logic         mode_en = 1'b0;
    logic         irq_en = 1'b0;
    logic         done_clr = 1'b0;
    logic         ser_out, tx_done, irq_req, tick_taken;

    int n_chk = 0;
    int n_fail = 0;

    // Bench model state
    logic [W-1:0] m_buf = '0;
    int           m_cnt = 0;
    logic         m_out = 1'b1;
    logic         m_done = 1'b0;
    logic         m_irq = 1'b0;

    always #2 clk = ~clk;

    sertx_top #(.DATA_W(W)) i_sertx_top (
        .clk(clk), .rst_n(rst_n), .buf_wr(buf_wr), .buf_data(buf_data),
        .baud_tick(baud_tick), .mode_en(mode_en), .irq_en(irq_en),
        .done_clr(done_clr), .ser_out(ser_out), .tx_done(tx_done),
        .irq_req(irq_req), .tick_taken(tick_taken)
    );

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic logic accept(input logic wr, input logic tk, input logic md, input int cnt);
        return tk && md && (cnt != 0) && !wr;
    endfunction

    function automatic logic pick_bit(input logic [W-1:0] b, input int idx);
        return b[idx];
    endfunction

    // One clock cycle: drive at negedge, check pulse, then registered outputs.
    task automatic step(input logic wr, input logic [W-1:0] d, input logic tk,
                        input logic md, input logic ie, input logic clr,
                        input string tag);
        logic take;
        logic last;
        buf_wr = wr; buf_data = d; baud_tick = tk;
        mode_en = md; irq_en = ie; done_clr = clr;
        #1;
        take = accept(wr, tk, md, m_cnt);
        chk({"R7 ", tag}, "tick_taken", 32'(tick_taken), 32'(take));
        last = take && (m_cnt == 1);
        @(posedge clk);
        if (wr) begin
            m_buf = d; m_cnt = W;
        end else if (take) begin
            m_cnt = m_cnt - 1;
            m_out = pick_bit(m_buf, m_cnt);
        end
        if (last) m_done = 1'b1; else if (clr) m_done = 1'b0;
        if (last && ie) m_irq = 1'b1; else if (clr) m_irq = 1'b0;
        #1;
        chk({"R3 ", tag}, "ser_out", 32'(ser_out), 32'(m_out));
        chk({"R5 ", tag}, "tx_done", 32'(tx_done), 32'(m_done));
        chk({"R6 ", tag}, "irq_req", 32'(irq_req), 32'(m_irq));
        @(negedge clk);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int seed;
        logic [31:0] r;
        seed = 32'd1234;
        r = $urandom(seed);
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", "ser_out", 32'(ser_out), 32'd1);
        chk("R1", "tx_done", 32'(tx_done), 32'd0);
        chk("R1", "irq_req", 32'(irq_req), 32'd0);
        chk("R1", "tick_taken", 32'(tick_taken), 32'd0);
        rst_n = 1'b1;

        // R8: ticks before any write are ignored
        for (int i = 0; i < 3; i++) step(0, '0, 1, 1, 1, 0, "R8 idle");

        // R2/R3/R5/R6: full frame MSB first with interrupt enabled
        step(1, 8'hA5, 0, 1, 1, 0, "R2 load");
        for (int i = 0; i < W; i++) begin
            step(0, '0, 1, 1, 1, 0, "R3 shift");
            step(0, '0, 0, 1, 1, 0, "R11 hold");
        end
        // R8: further ticks after completion are ignored
        for (int i = 0; i < 3; i++) step(0, '0, 1, 1, 1, 0, "R8 done");
        // R10: clear
        step(0, '0, 0, 1, 1, 1, "R10 clear");

        // R4: mode off ignores ticks
        step(1, 8'h3C, 0, 0, 0, 0, "R2 load");
        for (int i = 0; i < 4; i++) step(0, '0, 1, 0, 0, 0, "R4 mode off");
        // R9: write with tick same cycle, then restart mid-frame
        step(0, '0, 1, 1, 0, 0, "R3 shift");
        step(1, 8'h81, 1, 1, 0, 0, "R9 write beats tick");
        step(0, '0, 1, 1, 0, 0, "R9 after restart");
        step(1, 8'h7E, 0, 1, 0, 0, "R9 restart");
        // R6: completion with irq disabled, R10: clear at the completing tick
        for (int i = 0; i < W - 1; i++) step(0, '0, 1, 1, 0, 0, "R6 no irq");
        step(0, '0, 1, 1, 0, 1, "R10 set beats clear");
        step(0, '0, 0, 1, 0, 1, "R10 clear");

        // Random phase
        for (int i = 0; i < 4000; i++) begin
            r = $urandom;
            step((r[3:0] == 4'd0), W'($urandom), (r[5:4] != 2'd0),
                 (r[8:6] != 3'd0), r[9], (r[14:10] == 5'd0), "R2 random");
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule